// File: doc/BRIEF.md
# Card command issue and response capture engine

This block sits between a host-side command register and a card-side request channel. Software-facing logic writes an 11-bit command word and a 32-bit argument in the same cycle. If the word's enable bit is set and no command is in flight, the engine raises a request to the card side and carries the 6-bit index and the argument with it. It then waits for an acknowledge, which returns a byte count and up to 16 response bytes.

The returned count is checked against the response type that was asked for. A good response is packed big-endian into four 32-bit words and raises the response-done flag. A command that asked for no response raises the sent flag. Any mismatch, or a missing acknowledge before the programmable cycle limit runs out, raises the timeout flag when a response was expected. Once the outcome is known, the enable bit of the stored command word is cleared and the engine goes back to idle. Serial framing on the card line and CRC generation are not part of this block.

The controller has three states:
- `ST_IDLE`: no command in flight.
- `ST_WAIT`: the request is held high and cycles are counted.
- `ST_FINISH`: a single cycle in which the captured reply is judged and stored.

It has four transitions:
- IDLE to WAIT, on an accepted write with enable set.
- WAIT to FINISH, on acknowledge.
- WAIT to FINISH, on limit expiry.
- FINISH to IDLE, always.

Top module: `ccmd_engine`

## Requirements
- R1: A write (`cmd_wr_i`) while `busy_o` is low stores `cmd_wdata_i` into `cmd_word_o` and `cmd_arg_i` into `card_arg_o`. The command word has these fields:
  - bits 5:0: index.
  - bit 6: response wanted.
  - bit 7: long response.
  - bit 8: interrupt mode.
  - bit 9: pending mode.
  - bit 10: enable.
  
  If bit 10 is set, then from the next cycle `card_req_o` and `busy_o` are high and `card_index_o` shows bits 5:0.
- R2: A write while `busy_o` is high is ignored. It changes neither `cmd_word_o` nor `card_index_o` nor `card_arg_o`.
- R3: Response bytes arrive on `card_data_i` with byte k at bits [8k+7:8k]. Response word w appears on `resp_o[32w+31:32w]` and is built as {byte 4w, byte 4w+1, byte 4w+2, byte 4w+3}. If a response is wanted and the count is 4 with bit 7 clear, word 0 is loaded, words 1 to 3 become zero, and `resp_done_o` is set.
- R4: If a response is wanted and the count is 16, all four words are loaded, with bit 0 of word 3 forced to zero, and `resp_done_o` is set.
- R5: If a response is wanted and the count is 0, `timeout_o` is set and `resp_o` keeps its previous value.
- R6: If a long response is wanted and only 4 bytes return, `timeout_o` is set and `resp_o` is unchanged.
- R7: If a response is wanted, any count other than 4 or 16 sets `timeout_o` and leaves `resp_o` unchanged.
- R8: A command with bit 6 clear sets `sent_o` whatever count returns, and leaves `resp_o` unchanged.
- R9: Without an acknowledge, `card_req_o` stays high for exactly max(`tmo_limit_i`, 1) cycles. The outcome is then `timeout_o` if a response was wanted, and `sent_o` otherwise.
- R10: An acknowledge in the last cycle before the limit expires is taken as a reply, not as a timeout.
- R11: At completion, bit 10 of `cmd_word_o` is cleared, its other bits are kept, `busy_o` falls, and exactly one of the three flags is high. All three flags are cleared when the next command issues.
- R12: Bits 8 and 9 are stored and read back, but change neither the handshake nor the outcome.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 11 | Command word to store |
| cmd_arg_i | input | 32 | Argument stored with the command word |
| tmo_limit_i | input | 8 | Cycle limit for the acknowledge wait |
| card_req_o | output | 1 | Request to the card side |
| card_index_o | output | 6 | Command index presented with the request |
| card_arg_o | output | 32 | Stored argument |
| card_ack_i | input | 1 | Card-side acknowledge, one cycle |
| card_len_i | input | 5 | Number of response bytes returned |
| card_data_i | input | 128 | Response bytes, byte k at [8k+7:8k] |
| cmd_word_o | output | 11 | Stored command word |
| busy_o | output | 1 | Command in flight |
| resp_o | output | 128 | Four response words, word w at [32w+31:32w] |
| resp_done_o | output | 1 | Good response received |
| sent_o | output | 1 | Command without response completed |
| timeout_o | output | 1 | Missing or malformed response |

## Verification
Two events can fall in the same cycle here: the acknowledge and the expiry of the cycle limit. The bench provokes this by sweeping limits and placing the acknowledge exactly in the last cycle the request is still high. It judges the result by requiring the response flag rather than the timeout flag, and by requiring that the counted request cycles equal the limit. A second overlap, a command write landing while a command is in flight, is provoked mid-wait and judged by the stored word and the card-side index staying put.

// File: rtl/ccmd_pkg.sv
package ccmd_pkg;
    localparam int CMD_W  = 11;
    localparam int IDX_W  = 6;
    localparam int B_RESP = 6;
    localparam int B_LONG = 7;
    localparam int B_IRQ  = 8;
    localparam int B_PEND = 9;
    localparam int B_EN   = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_FINISH = 2'd2
    } ccmd_state_e;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_RESP = 2'd1,
        OUT_SENT = 2'd2,
        OUT_TMO  = 2'd3
    } ccmd_outcome_e;
endpackage

// File: rtl/ccmd_timer.sv
module ccmd_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_next[TMO_W-1:0];
        end else begin
            cnt_q <= '0;
        end
    end

    // a zero limit behaves as a limit of one cycle
    assign expire_o = run_i && (cnt_next >= {1'b0, limit_i});
endmodule

// File: rtl/ccmd_fsm.sv
module ccmd_fsm
    import ccmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_i,
    input  logic        ack_i,
    input  logic        expire_i,
    output ccmd_state_e state_o,
    output logic        req_o,
    output logic        busy_o,
    output logic        capture_o,
    output logic        lapse_o,
    output logic        finish_o
);
    ccmd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue_i) state_d = ST_WAIT;
            ST_WAIT:   if (ack_i || expire_i) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o     = 1'b0;
        busy_o    = 1'b0;
        capture_o = 1'b0;
        lapse_o   = 1'b0;
        finish_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                req_o     = 1'b1;
                busy_o    = 1'b1;
                capture_o = ack_i;
                lapse_o   = !ack_i && expire_i;
            end
            ST_FINISH: begin
                busy_o   = 1'b1;
                finish_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ccmd_judge.sv
module ccmd_judge
    import ccmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5
) (
    input  logic                     want_resp_i,
    input  logic                     want_long_i,
    input  logic                     acked_i,
    input  logic [LEN_W-1:0]         len_i,
    input  logic [NWORDS*WORD_W-1:0] data_i,
    output ccmd_outcome_e            outcome_o,
    output logic                     load_o,
    output logic [NWORDS*WORD_W-1:0] words_o
);
    localparam int BPW        = WORD_W / 8;
    localparam int SHORT_LEN  = BPW;
    localparam int LONG_LEN   = NWORDS * BPW;

    logic len_short, len_long;
    logic [NWORDS-1:0][WORD_W-1:0] raw;

    assign len_short = (len_i == LEN_W'(SHORT_LEN));
    assign len_long  = (len_i == LEN_W'(LONG_LEN));

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign raw[w][WORD_W-1-8*b -: 8] = data_i[8*(BPW*w+b) +: 8];
        end
        if (w == 0) begin : g_first
            assign words_o[w*WORD_W +: WORD_W] = raw[w];
        end else if (w == NWORDS-1) begin : g_last
            assign words_o[w*WORD_W +: WORD_W] =
                len_long ? {raw[w][WORD_W-1:1], 1'b0} : '0;
        end else begin : g_mid
            assign words_o[w*WORD_W +: WORD_W] = len_long ? raw[w] : '0;
        end
    end

    always_comb begin
        outcome_o = OUT_NONE;
        load_o    = 1'b0;
        if (!acked_i) begin
            outcome_o = want_resp_i ? OUT_TMO : OUT_SENT;
        end else if (!want_resp_i) begin
            outcome_o = OUT_SENT;
        end else if (len_long || (len_short && !want_long_i)) begin
            outcome_o = OUT_RESP;
            load_o    = 1'b1;
        end else begin
            outcome_o = OUT_TMO;
        end
    end
endmodule

// File: rtl/ccmd_engine.sv
module ccmd_engine
    import ccmd_pkg::*;
#(
    parameter int ARG_W  = 32,
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5,
    parameter int TMO_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr_i,
    input  logic [CMD_W-1:0]         cmd_wdata_i,
    input  logic [ARG_W-1:0]         cmd_arg_i,
    input  logic [TMO_W-1:0]         tmo_limit_i,
    output logic                     card_req_o,
    output logic [IDX_W-1:0]         card_index_o,
    output logic [ARG_W-1:0]         card_arg_o,
    input  logic                     card_ack_i,
    input  logic [LEN_W-1:0]         card_len_i,
    input  logic [NWORDS*WORD_W-1:0] card_data_i,
    output logic [CMD_W-1:0]         cmd_word_o,
    output logic                     busy_o,
    output logic [NWORDS*WORD_W-1:0] resp_o,
    output logic                     resp_done_o,
    output logic                     sent_o,
    output logic                     timeout_o
);
    localparam int RESP_W = NWORDS * WORD_W;

    logic [CMD_W-1:0]  cmd_q;
    logic [ARG_W-1:0]  arg_q;
    logic [LEN_W-1:0]  cap_len_q;
    logic [RESP_W-1:0] cap_data_q;
    logic              cap_acked_q;
    logic [RESP_W-1:0] resp_q;
    logic              f_resp_q, f_sent_q, f_tmo_q;

    logic          accept, issue, expire;
    logic          req, busy, capture, lapse, finish;
    ccmd_state_e   state;
    ccmd_outcome_e outcome;
    logic          load;
    logic [RESP_W-1:0] words;

    assign accept = cmd_wr_i && !busy;
    assign issue  = accept && cmd_wdata_i[B_EN];

    ccmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue),
        .ack_i     (card_ack_i),
        .expire_i  (expire),
        .state_o   (state),
        .req_o     (req),
        .busy_o    (busy),
        .capture_o (capture),
        .lapse_o   (lapse),
        .finish_o  (finish)
    );

    ccmd_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state == ST_WAIT),
        .limit_i  (tmo_limit_i),
        .expire_o (expire)
    );

    ccmd_judge #(.WORD_W(WORD_W), .NWORDS(NWORDS), .LEN_W(LEN_W)) u_judge (
        .want_resp_i (cmd_q[B_RESP]),
        .want_long_i (cmd_q[B_LONG]),
        .acked_i     (cap_acked_q),
        .len_i       (cap_len_q),
        .data_i      (cap_data_q),
        .outcome_o   (outcome),
        .load_o      (load),
        .words_o     (words)
    );

    // command word and argument
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            arg_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_wdata_i;
            arg_q <= cmd_arg_i;
        end else if (finish) begin
            cmd_q[B_EN] <= 1'b0;
        end
    end

    // reply capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_len_q   <= '0;
            cap_data_q  <= '0;
            cap_acked_q <= 1'b0;
        end else if (capture) begin
            cap_len_q   <= card_len_i;
            cap_data_q  <= card_data_i;
            cap_acked_q <= 1'b1;
        end else if (lapse) begin
            cap_acked_q <= 1'b0;
        end
    end

    // response words and completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q   <= '0;
            f_resp_q <= 1'b0;
            f_sent_q <= 1'b0;
            f_tmo_q  <= 1'b0;
        end else if (issue) begin
            f_resp_q <= 1'b0;
            f_sent_q <= 1'b0;
            f_tmo_q  <= 1'b0;
        end else if (finish) begin
            if (load) resp_q <= words;
            f_resp_q <= (outcome == OUT_RESP);
            f_sent_q <= (outcome == OUT_SENT);
            f_tmo_q  <= (outcome == OUT_TMO);
        end
    end

    assign card_req_o   = req;
    assign card_index_o = cmd_q[IDX_W-1:0];
    assign card_arg_o   = arg_q;
    assign cmd_word_o   = cmd_q;
    assign busy_o       = busy;
    assign resp_o       = resp_q;
    assign resp_done_o  = f_resp_q;
    assign sent_o       = f_sent_q;
    assign timeout_o    = f_tmo_q;
endmodule

// File: rtl/ccmd_engine_chk.sv
module ccmd_engine_chk #(
    parameter int ARG_W  = 32,
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5,
    parameter int TMO_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_wr_i,
    input logic [TMO_W-1:0]         tmo_limit_i,
    input logic                     card_req_o,
    input logic [5:0]               card_index_o,
    input logic [10:0]              cmd_word_o,
    input logic                     busy_o,
    input logic [NWORDS*WORD_W-1:0] resp_o,
    input logic                     resp_done_o,
    input logic                     sent_o,
    input logic                     timeout_o
);
    logic [TMO_W:0] req_run_q;
    logic [TMO_W:0] lim_eff;

    assign lim_eff = (tmo_limit_i == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_limit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_run_q <= '0;
        else if (card_req_o) req_run_q <= req_run_q + 1'b1;
        else req_run_q <= '0;
    end

    // R1
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_o |-> busy_o);

    // R2
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_wr_i && card_req_o) |=> $stable(card_index_o));

    // R4
    last_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_done_o) |-> (resp_o[(NWORDS-1)*WORD_W] == 1'b0));

    // R9
    req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_o |-> (req_run_q < lim_eff));

    // R11
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($countones({resp_done_o, sent_o, timeout_o}) == 1));

    // R11
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_done_o, sent_o, timeout_o}));

    // R11
    enable_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !cmd_word_o[10]);
endmodule

bind ccmd_engine ccmd_engine_chk #(
    .ARG_W(ARG_W), .WORD_W(WORD_W), .NWORDS(NWORDS), .LEN_W(LEN_W), .TMO_W(TMO_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr_i     (cmd_wr_i),
    .tmo_limit_i  (tmo_limit_i),
    .card_req_o   (card_req_o),
    .card_index_o (card_index_o),
    .cmd_word_o   (cmd_word_o),
    .busy_o       (busy_o),
    .resp_o       (resp_o),
    .resp_done_o  (resp_done_o),
    .sent_o       (sent_o),
    .timeout_o    (timeout_o)
);

// File: tb/ccmd_engine_tb_top.sv
module ccmd_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr_i = 1'b0;
    logic [10:0]  cmd_wdata_i = '0;
    logic [31:0]  cmd_arg_i = '0;
    logic [7:0]   tmo_limit_i = 8'd8;
    logic         card_req_o;
    logic [5:0]   card_index_o;
    logic [31:0]  card_arg_o;
    logic         card_ack_i = 1'b0;
    logic [4:0]   card_len_i = '0;
    logic [127:0] card_data_i = '0;
    logic [10:0]  cmd_word_o;
    logic         busy_o;
    logic [127:0] resp_o;
    logic         resp_done_o, sent_o, timeout_o;

    int n_chk = 0;
    int n_fail = 0;
    int req_cnt = 0;
    logic [127:0] resp_model = '0;

    always #5 clk = ~clk;

    ccmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_wdata_i(cmd_wdata_i),
        .cmd_arg_i(cmd_arg_i), .tmo_limit_i(tmo_limit_i), .card_req_o(card_req_o),
        .card_index_o(card_index_o), .card_arg_o(card_arg_o), .card_ack_i(card_ack_i),
        .card_len_i(card_len_i), .card_data_i(card_data_i), .cmd_word_o(cmd_word_o),
        .busy_o(busy_o), .resp_o(resp_o), .resp_done_o(resp_done_o), .sent_o(sent_o),
        .timeout_o(timeout_o)
    );

    always @(negedge clk) if (card_req_o) req_cnt <= req_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_data(input int seed);
        logic [127:0] d;
        for (int k = 0; k < 16; k++) d[8*k +: 8] = 8'((seed + 37*k + 5) & 255);
        return d;
    endfunction

    // 0 response, 1 sent, 2 timeout
    function automatic int exp_out(input bit wr, input bit wl, input bit acked, input int len);
        if (!acked) return wr ? 2 : 1;
        if (!wr) return 1;
        if (len == 16) return 0;
        if (len == 4 && !wl) return 0;
        return 2;
    endfunction

    function automatic logic [127:0] exp_words(input logic [127:0] d, input int len);
        logic [127:0] r = '0;
        for (int w = 0; w < 4; w++)
            for (int j = 0; j < 4; j++)
                r[32*w + 31 - 8*j -: 8] = d[8*(4*w+j) +: 8];
        if (len == 4) r[127:32] = '0;
        else r[96] = 1'b0;
        return r;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    // issue one command; ack after delay cycles (or never), then judge
    task automatic run_cmd(input logic [10:0] cmd, input logic [31:0] arg, input int delay,
                           input bit give_ack, input int len, input logic [127:0] d,
                           input int lim, input string tag);
        int eo, lim_eff;
        logic [2:0] ef;
        tmo_limit_i = 8'(lim);
        lim_eff = (lim == 0) ? 1 : lim;
        @(negedge clk);
        req_cnt = 0;
        cmd_wr_i = 1'b1; cmd_wdata_i = cmd; cmd_arg_i = arg;
        @(negedge clk);
        cmd_wr_i = 1'b0;
        // R1 R11: issue state and cleared flags
        chk(card_req_o && busy_o && card_index_o == cmd[5:0] && card_arg_o == arg,
            {tag, " R1 issue"}, {card_req_o, busy_o, card_index_o, card_arg_o},
            {1'b1, 1'b1, cmd[5:0], arg});
        chk({resp_done_o, sent_o, timeout_o} == 3'b000, {tag, " R11 flags cleared"},
            {resp_done_o, sent_o, timeout_o}, 0);
        repeat (delay) @(negedge clk);
        if (give_ack) begin
            card_ack_i = 1'b1; card_len_i = 5'(len); card_data_i = d;
            @(negedge clk);
            card_ack_i = 1'b0;
        end
        wait_idle();
        eo = exp_out(cmd[6], cmd[7], give_ack, len);
        ef = (eo == 0) ? 3'b100 : (eo == 1) ? 3'b010 : 3'b001;
        if (eo == 0) resp_model = exp_words(d, len);
        chk({resp_done_o, sent_o, timeout_o} == ef, {tag, " R3-outcome R5 R6 R7 R8"},
            {resp_done_o, sent_o, timeout_o}, ef);
        chk(resp_o == resp_model, {tag, " R3 R4 words"}, resp_o, resp_model);
        chk(cmd_word_o == (cmd & 11'h3ff), {tag, " R11 R12 stored word"}, cmd_word_o,
            cmd & 11'h3ff);
        chk(req_cnt == (give_ack ? delay + 1 : lim_eff), {tag, " R9 req cycles"},
            req_cnt, give_ack ? delay + 1 : lim_eff);
    endtask

    initial begin
        #1;
        // R13 reset state
        chk({card_req_o, card_index_o, card_arg_o, cmd_word_o, busy_o, resp_done_o,
             sent_o, timeout_o} == '0 && resp_o == '0, "R13 reset", resp_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(!busy_o && resp_o == '0, "R13 after release", {busy_o, resp_o[31:0]}, 0);

        // sweep: every count x response kind x long flag, with mode bits 8/9 varied (R12)
        for (int len = 0; len < 32; len++)
            for (int k = 0; k < 4; k++) begin
                logic [10:0] c;
                c = {1'b1, 1'(len), 1'(len >> 1), 1'(k >> 1), 1'(k), 6'(len + 3*k)};
                run_cmd(c, 32'hA500_0000 + 32'(len * 4 + k), (len + k) % 4, 1'b1, len,
                        mk_data(len * 7 + k), 10, "sweep");
            end

        // R9 expiry without ack, both kinds, limits 0..5
        for (int lim = 0; lim < 6; lim++)
            for (int wr = 0; wr < 2; wr++)
                run_cmd({1'b1, 2'b00, 1'b0, 1'(wr), 6'(lim + 40)}, 32'(lim), 0, 1'b0, 0,
                        '0, lim, "R9 expiry");

        // R10 ack in the final allowed cycle beats expiry
        for (int lim = 1; lim < 6; lim++)
            run_cmd({1'b1, 2'b00, 1'b1, 1'b1, 6'(lim)}, 32'hBEEF, lim - 1, 1'b1, 16,
                    mk_data(lim + 99), lim, "R10 last-cycle ack");

        // R2 write while busy is ignored
        begin
            tmo_limit_i = 8'd6;
            @(negedge clk);
            cmd_wr_i = 1'b1; cmd_wdata_i = {1'b1, 4'b0001, 6'd17}; cmd_arg_i = 32'h1111;
            @(negedge clk);
            cmd_wdata_i = {1'b1, 4'b0110, 6'd33}; cmd_arg_i = 32'h2222;
            @(negedge clk);
            cmd_wr_i = 1'b0;
            chk(cmd_word_o == {1'b1, 4'b0001, 6'd17} && card_index_o == 6'd17 &&
                card_arg_o == 32'h1111, "R2 busy write", {cmd_word_o, card_arg_o},
                {11'h451, 32'h1111});
            wait_idle();
            chk(cmd_word_o == {1'b0, 4'b0001, 6'd17} && timeout_o, "R2 R9 after expiry",
                {cmd_word_o, timeout_o}, {11'h051, 1'b1});
        end

        // write with enable clear: stored, no request
        @(negedge clk);
        cmd_wr_i = 1'b1; cmd_wdata_i = {1'b0, 4'b0011, 6'd9}; cmd_arg_i = 32'h77;
        @(negedge clk);
        cmd_wr_i = 1'b0;
        chk(!card_req_o && !busy_o && cmd_word_o == {1'b0, 4'b0011, 6'd9} &&
            card_arg_o == 32'h77, "R1 store without enable",
            {card_req_o, busy_o, cmd_word_o}, {2'b00, 11'h0C9});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R13 actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule